// File: doc/BRIEF.md
# Masked Interrupt Router for Four CPUs

The router gathers numbered interrupt requests from devices and spreads them across four CPUs. Every device owns its own interrupt number, from 0 to 63. A post marks that number active in a shared 64-bit pending vector. A clear removes it. Each CPU owns a 64-bit enable mask, and its routed vector is always the AND of that mask with the pending vector.

Changes leave the block as per-CPU events. Each event states whether it posts or withdraws a number and carries that number. A post or a real clear produces one event cycle, delivered in parallel to every CPU concerned. A mask write can affect up to 64 numbers for one CPU. The sequencer therefore walks bits 0 to 63 in ascending order, one bit per cycle, and keeps ready low for the whole walk. Requests offered while ready is low are not taken.

Top module: `irq_route_top`

## Requirements
- R1: After reset every mask, the pending vector and every routed vector are zero, ready_o is 1, and evt_valid_o, spur_o and err_o are 0.
- R2: A post of number k accepted on one clock edge sets pending bit k. In the following cycle the block shows evt_clr_o=0 and evt_id_o=k, and evt_valid_o bit n is 1 exactly for the CPUs whose mask has bit k set. ready_o is 0 in that cycle.
- R3: A clear of number k while pending bit k is 1 clears that bit. In the following cycle the block shows evt_clr_o=1 and evt_id_o=k, with evt_valid_o set for each CPU whose routed vector had bit k set before the clear. ready_o is 0 in that cycle.
- R4: A clear of number k while pending bit k is 0 changes no state. It pulses spur_o in the following cycle with no event, and ready_o stays 1.
- R5: Each CPU's routed vector equals its mask AND the pending vector at all times. This shows in the CPU sets of later post and clear events.
- R6: A write with wr_sel_i = n (0 to 3) replaces CPU n's mask and starts a 64-cycle walk. In walk cycle i (i = 0 first, the cycle after acceptance), evt_id_o=i. If mask bit i changed, evt_valid_o carries only bit n, with evt_clr_o=0 when bit i of both the new mask and the pending vector is set, and evt_clr_o=1 otherwise. If the bit did not change, evt_valid_o is 0. ready_o is 0 throughout the walk.
- R7: A write with wr_sel_i from 4 to 15 (the routed vectors, the pending vector or no register) changes nothing. It pulses err_o in the following cycle, and ready_o stays 1.
- R8: Any post, clear or write held on the inputs while ready_o is 0 is not taken and has no effect.
- R9: When more than one request is valid in a ready cycle, only one is taken, a post before a clear before a write. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_o | output | 1 | Request inputs are taken this cycle |
| post_valid_i | input | 1 | Post request |
| post_id_i | input | 6 | Interrupt number to post |
| clr_valid_i | input | 1 | Clear request |
| clr_id_i | input | 6 | Interrupt number to clear |
| wr_valid_i | input | 1 | Register write request |
| wr_sel_i | input | 4 | Register index; 0-3 are CPU masks |
| wr_data_i | input | 64 | Write data |
| evt_valid_o | output | 4 | Per-CPU event strobe |
| evt_clr_o | output | 1 | Event kind: 1 withdraw, 0 post |
| evt_id_o | output | 6 | Event interrupt number |
| spur_o | output | 1 | Clear of a number that was not pending |
| err_o | output | 1 | Write to an unsupported register index |

## Verification
The assertions assume that requests enter only through the ready gate. They assume no request arrives while a walk or an event cycle is in flight, and that the routed vectors start from the all-zero reset image. The bench drives one request at a time, each after it sees ready_o high on a falling edge. The one exception is the deliberate priority test, which raises all three request strobes together. The other is a post held during a mask walk, placed there to confirm it is ignored.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ONE, SEQ_SCAN} seq_state_e;
  typedef enum logic [1:0] {OP_NONE, OP_POST, OP_CLR, OP_MASK} op_e;
endpackage

// File: rtl/irq_wr_dec.sv
module irq_wr_dec
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int SEL_W   = 4
) (
  input  logic               ready_i,
  input  logic               post_valid_i,
  input  logic               clr_valid_i,
  input  logic               wr_valid_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  output op_e                op_o,
  output logic [NUM_CPU-1:0] mask_we_o,
  output logic               bad_wr_o
);
  logic sel_ok;
  assign sel_ok = wr_sel_i < SEL_W'(NUM_CPU);

  // fixed priority: post, clear, write
  always_comb begin
    op_o     = OP_NONE;
    bad_wr_o = 1'b0;
    if (ready_i) begin
      if (post_valid_i)     op_o = OP_POST;
      else if (clr_valid_i) op_o = OP_CLR;
      else if (wr_valid_i) begin
        if (sel_ok) op_o = OP_MASK;
        else        bad_wr_o = 1'b1;
      end
    end
  end

  for (genvar n = 0; n < NUM_CPU; n++) begin : g_we
    assign mask_we_o[n] = (op_o == OP_MASK) && (wr_sel_i == SEL_W'(n));
  end
endmodule

// File: rtl/irq_state.sv
module irq_state
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int IDW    = $clog2(NUM_IRQ)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  op_e                               op_i,
  input  logic [IDW-1:0]                    post_id_i,
  input  logic [IDW-1:0]                    clr_id_i,
  input  logic [NUM_CPU-1:0]                mask_we_i,
  input  logic [NUM_IRQ-1:0]                wr_data_i,
  output logic [NUM_IRQ-1:0]                raw_o,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0]   mask_o,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0]   dir_o,
  output logic                              spur_o
);
  logic [NUM_IRQ-1:0] raw_q, raw_d;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] mask_q, dir_q;

  assign spur_o = (op_i == OP_CLR) && !raw_q[clr_id_i];

  always_comb begin
    raw_d = raw_q;
    if (op_i == OP_POST) raw_d[post_id_i] = 1'b1;
    if (op_i == OP_CLR)  raw_d[clr_id_i]  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_d;
  end

  for (genvar n = 0; n < NUM_CPU; n++) begin : g_cpu
    logic [NUM_IRQ-1:0] mask_d;
    assign mask_d = mask_we_i[n] ? wr_data_i : mask_q[n];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[n] <= '0;
        dir_q[n]  <= '0;
      end else begin
        mask_q[n] <= mask_d;
        dir_q[n]  <= mask_d & raw_d;
      end
    end

    // R5
    dir_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_q[n] == (mask_q[n] & raw_q));
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign dir_o  = dir_q;

  // R4
  spur_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spur_o |=> ($stable(raw_q) && $stable(mask_q)));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int IDW    = $clog2(NUM_IRQ),
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  op_e                             op_i,
  input  logic [IDW-1:0]                  post_id_i,
  input  logic [IDW-1:0]                  clr_id_i,
  input  logic [CPU_W-1:0]                wr_cpu_i,
  input  logic [NUM_IRQ-1:0]              wr_data_i,
  input  logic [NUM_IRQ-1:0]              raw_i,
  input  logic [NUM_CPU-1:0][NUM_IRQ-1:0] mask_i,
  input  logic [NUM_CPU-1:0][NUM_IRQ-1:0] dir_i,
  input  logic                            spur_i,
  input  logic                            bad_wr_i,
  output logic                            ready_o,
  output logic [NUM_CPU-1:0]              evt_valid_o,
  output logic                            evt_clr_o,
  output logic [IDW-1:0]                  evt_id_o,
  output logic                            spur_o,
  output logic                            err_o
);
  localparam logic [IDW-1:0] LAST = IDW'(NUM_IRQ - 1);

  seq_state_e         state_q;
  logic [NUM_CPU-1:0] cpu_vec_q, post_vec, clr_vec;
  logic               kind_q;
  logic [IDW-1:0]     id_q;
  logic [CPU_W-1:0]   cpu_q;
  logic [NUM_IRQ-1:0] chg_q, dsnap_q;

  for (genvar n = 0; n < NUM_CPU; n++) begin : g_col
    assign post_vec[n] = mask_i[n][post_id_i];
    assign clr_vec[n]  = dir_i[n][clr_id_i];  // routed bit before the clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      cpu_vec_q <= '0;
      kind_q    <= 1'b0;
      id_q      <= '0;
      cpu_q     <= '0;
      chg_q     <= '0;
      dsnap_q   <= '0;
      spur_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      spur_o <= spur_i;
      err_o  <= bad_wr_i;
      unique case (state_q)
        SEQ_IDLE: begin
          unique case (op_i)
            OP_POST: begin
              cpu_vec_q <= post_vec;
              kind_q    <= 1'b0;
              id_q      <= post_id_i;
              state_q   <= SEQ_ONE;
            end
            OP_CLR: if (!spur_i) begin
              cpu_vec_q <= clr_vec;
              kind_q    <= 1'b1;
              id_q      <= clr_id_i;
              state_q   <= SEQ_ONE;
            end
            OP_MASK: begin
              chg_q   <= mask_i[wr_cpu_i] ^ wr_data_i;
              dsnap_q <= wr_data_i & raw_i;
              cpu_q   <= wr_cpu_i;
              id_q    <= '0;
              state_q <= SEQ_SCAN;
            end
            default: ;
          endcase
        end
        SEQ_ONE: state_q <= SEQ_IDLE;
        SEQ_SCAN: begin
          id_q <= id_q + 1'b1;
          if (id_q == LAST) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == SEQ_IDLE);

  always_comb begin
    evt_valid_o = '0;
    evt_clr_o   = 1'b0;
    evt_id_o    = '0;
    if (state_q == SEQ_ONE) begin
      evt_valid_o = cpu_vec_q;
      evt_clr_o   = kind_q;
      evt_id_o    = id_q;
    end else if (state_q == SEQ_SCAN) begin
      evt_valid_o = chg_q[id_q] ? (NUM_CPU'(1) << cpu_q) : '0;
      evt_clr_o   = !dsnap_q[id_q];
      evt_id_o    = id_q;
    end
  end

  // R2
  post_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POST) |=> (!ready_o && !evt_clr_o));
  // R6
  scan_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_SCAN) |-> $onehot0(evt_valid_o));
  // R6
  scan_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_SCAN && id_q != LAST) |=> (state_q == SEQ_SCAN));
  // R4
  spur_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spur_o |-> (ready_o && evt_valid_o == '0));
  // R7
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && evt_valid_o == '0));
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int NUM_IRQ  = 64,
  parameter int SEL_W    = 4,
  localparam int IDW     = $clog2(NUM_IRQ),
  localparam int CPU_W   = $clog2(NUM_CPU)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               ready_o,
  input  logic               post_valid_i,
  input  logic [IDW-1:0]     post_id_i,
  input  logic               clr_valid_i,
  input  logic [IDW-1:0]     clr_id_i,
  input  logic               wr_valid_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [NUM_IRQ-1:0] wr_data_i,
  output logic [NUM_CPU-1:0] evt_valid_o,
  output logic               evt_clr_o,
  output logic [IDW-1:0]     evt_id_o,
  output logic               spur_o,
  output logic               err_o
);
  op_e                             op_w;
  logic [NUM_CPU-1:0]              mask_we_w;
  logic                            bad_wr_w, spur_w;
  logic [NUM_IRQ-1:0]              raw_w;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] mask_w, dir_w;

  irq_wr_dec #(.NUM_CPU(NUM_CPU), .SEL_W(SEL_W)) dec_i (
    .ready_i     (ready_o),
    .post_valid_i(post_valid_i),
    .clr_valid_i (clr_valid_i),
    .wr_valid_i  (wr_valid_i),
    .wr_sel_i    (wr_sel_i),
    .op_o        (op_w),
    .mask_we_o   (mask_we_w),
    .bad_wr_o    (bad_wr_w)
  );

  irq_state #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) state_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_w),
    .post_id_i(post_id_i),
    .clr_id_i (clr_id_i),
    .mask_we_i(mask_we_w),
    .wr_data_i(wr_data_i),
    .raw_o    (raw_w),
    .mask_o   (mask_w),
    .dir_o    (dir_w),
    .spur_o   (spur_w)
  );

  irq_seq #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op_w),
    .post_id_i  (post_id_i),
    .clr_id_i   (clr_id_i),
    .wr_cpu_i   (wr_sel_i[CPU_W-1:0]),
    .wr_data_i  (wr_data_i),
    .raw_i      (raw_w),
    .mask_i     (mask_w),
    .dir_i      (dir_w),
    .spur_i     (spur_w),
    .bad_wr_i   (bad_wr_w),
    .ready_o    (ready_o),
    .evt_valid_o(evt_valid_o),
    .evt_clr_o  (evt_clr_o),
    .evt_id_o   (evt_id_o),
    .spur_o     (spur_o),
    .err_o      (err_o)
  );

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ($stable(raw_w) && $stable(mask_w)));
  // R7
  bad_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr_w |=> ($stable(raw_w) && $stable(mask_w)));
endmodule

// File: tb/irq_route_top_tb_top.sv
module irq_route_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ready;
  logic        post_valid = 1'b0;
  logic [5:0]  post_id = '0;
  logic        clr_valid = 1'b0;
  logic [5:0]  clr_id = '0;
  logic        wr_valid = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  evt_valid;
  logic        evt_clr;
  logic [5:0]  evt_id;
  logic        spur, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_mask [4];
  logic [63:0] m_raw;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ready_o(ready),
    .post_valid_i(post_valid), .post_id_i(post_id),
    .clr_valid_i(clr_valid), .clr_id_i(clr_id),
    .wr_valid_i(wr_valid), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .evt_valid_o(evt_valid), .evt_clr_o(evt_clr), .evt_id_o(evt_id),
    .spur_o(spur), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic do_post(input int k);
    logic [3:0] ev;
    logic [11:0] act, exp;
    wait_ready();
    post_valid = 1'b1; post_id = 6'(k);
    for (int n = 0; n < 4; n++) ev[n] = m_mask[n][k];
    m_raw[k] = 1'b1;
    @(negedge clk);
    post_valid = 1'b0;
    act = {ready, evt_clr, evt_id, evt_valid};
    exp = {1'b0, 1'b0, 6'(k), ev};
    chk(act == exp, "R2/R5 post event", 64'(act), 64'(exp));
  endtask

  task automatic do_clr(input int k);
    logic [3:0] ev;
    logic [12:0] act, exp;
    wait_ready();
    clr_valid = 1'b1; clr_id = 6'(k);
    for (int n = 0; n < 4; n++) ev[n] = m_mask[n][k] & m_raw[k];
    @(negedge clk);
    clr_valid = 1'b0;
    if (m_raw[k]) begin
      m_raw[k] = 1'b0;
      act = {spur, ready, evt_clr, evt_id, evt_valid};
      exp = {1'b0, 1'b0, 1'b1, 6'(k), ev};
      chk(act == exp, "R3/R5 clear event", 64'(act), 64'(exp));
    end else begin
      act = {7'b0, spur, ready, evt_valid};
      exp = {7'b0, 1'b1, 1'b1, 4'b0};
      chk(act == exp, "R4 spurious clear", 64'(act), 64'(exp));
    end
  endtask

  task automatic do_wr(input int sel, input logic [63:0] data, input bit poke);
    logic [63:0] old;
    logic [11:0] act, exp;
    wait_ready();
    wr_valid = 1'b1; wr_sel = 4'(sel); wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
    if (sel < 4) begin
      old = m_mask[sel];
      m_mask[sel] = data;
      for (int i = 0; i < 64; i++) begin
        if (old[i] ^ data[i]) begin
          act = {ready, evt_clr, evt_id, evt_valid};
          exp = {1'b0, !(data[i] & m_raw[i]), 6'(i), 4'(1 << sel)};
          chk(act == exp, "R6 walk event", 64'(act), 64'(exp));
        end else begin
          act = {6'b0, ready, evt_id == 6'(i), evt_valid};
          exp = {6'b0, 1'b0, 1'b1, 4'b0};
          chk(act == exp, "R6 walk quiet", 64'(act), 64'(exp));
        end
        if (poke && i == 5) begin post_valid = 1'b1; post_id = 6'd10; end
        if (poke && i == 7) post_valid = 1'b0;
        if (i < 63) @(negedge clk);
      end
      @(negedge clk);
      chk(ready == 1'b1, "R6 walk end", 64'(ready), 64'd1);
    end else begin
      act = {6'b0, err, ready, evt_valid};
      exp = {6'b0, 1'b1, 1'b1, 4'b0};
      chk(act == exp, "R7 unsupported write", 64'(act), 64'(exp));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [3:0] ev;
    logic [11:0] act, exp;
    for (int n = 0; n < 4; n++) m_mask[n] = '0;
    m_raw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({ready, evt_valid, spur, err} == 7'b1000000, "R1 reset outputs",
        64'({ready, evt_valid, spur, err}), 64'h40);
    do_clr(0);  // R1 pending empty
    do_clr(63);

    do_wr(0, '1, 1'b0);
    do_wr(1, 64'h5555_5555_5555_5555, 1'b0);
    do_wr(2, 64'hFFFF_0000_FFFF_0000, 1'b0);
    do_wr(3, 64'h0, 1'b0);

    for (int k = 0; k < 64; k++) do_post(k);
    do_post(7);  // repeat post of a pending number

    // R7 unsupported indices, state untouched afterwards
    for (int s = 4; s < 16; s += 3) do_wr(s, '1, 1'b0);
    do_wr(8, '0, 1'b0);

    do_wr(3, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0);
    do_wr(0, 64'h0000_0000_FFFF_FFFF, 1'b0);

    for (int k = 0; k < 64; k += 2) do_clr(k);
    do_clr(0);
    do_clr(62);

    // R8 post held during a walk must be ignored
    do_wr(1, '1, 1'b1);
    do_clr(10);

    // R9 priority post > clear > write
    wait_ready();
    post_valid = 1'b1; post_id = 6'd20;
    clr_valid = 1'b1;  clr_id = 6'd21;
    wr_valid = 1'b1;   wr_sel = 4'd0; wr_data = '0;
    for (int n = 0; n < 4; n++) ev[n] = m_mask[n][20];
    m_raw[20] = 1'b1;
    @(negedge clk);
    post_valid = 1'b0; clr_valid = 1'b0; wr_valid = 1'b0;
    act = {ready, evt_clr, evt_id, evt_valid};
    exp = {1'b0, 1'b0, 6'd20, ev};
    chk(act == exp, "R9 post wins", 64'(act), 64'(exp));
    do_clr(21);
    do_clr(20);
    do_clr(63);
    do_post(63);
    do_clr(63);

    done = 1'b1;
    finish_run();
  end
endmodule